// File: doc/BRIEF.md
# External Bus Chip-Select Window Decoder

The decoder sits in front of an external asynchronous memory bus. It compares the upper address bits of each bus request with six programmable windows. Each window holds a base value, a don't-care mask, a valid flag and a control word. The control word selects the port width, burst permission and termination style. The registered result appears one clock after the request and takes one of four forms:

- an idle indication when no request was made;
- an internal termination with every chip-select inactive when nothing matches;
- a single asserted chip-select carrying that window's attributes;
- several asserted chip-selects with a forced safe cycle type (no burst, external termination, full 32-bit width).

After reset the block is in boot mode, which lets a boot memory answer before any software has run. While window 0 is not valid, window 0 claims every request whatever its address, and windows 1 to 5 are held off. The boot window's port width is taken from two strap pins sampled during reset. Once software sets the valid flag of window 0, every window decodes from its own base and mask. A small write port programs the windows; a write is seen by requests from the following clock onward.

Top module: `cs_window_decoder`

## Requirements
- R1: All outputs are registered and change only on a rising clock edge. A request presented at one edge produces its result after that edge, and `cyc_addr`/`cyc_write` echo it. A clock with `req_valid` low gives outcome IDLE (2'b00), all `cs_n` high, and zero attributes, lanes and address. Reset gives the same idle state.
- R2: When no window matches, the outcome is NONE (2'b01), all `cs_n` are high, and `cyc_ext_term`, `cyc_burst_en`, `cyc_port_size` and `cyc_lanes` are zero.
- R3: When exactly one window matches, the outcome is SINGLE (2'b10) and only that window's `cs_n` bit is low. `cyc_port_size` and `cyc_burst_en` are taken from the window's control word, and `cyc_ext_term` is the inverse of its auto-acknowledge bit.
- R4: When two or more windows match, the outcome is MULTI (2'b11) and every matching `cs_n` bit is low. `cyc_burst_en` is forced to 0, `cyc_ext_term` to 1, `cyc_port_size` to 2'b00 and `cyc_lanes` to 4'b1111.
- R5: While window 0 is not valid (boot mode), every request yields SINGLE with only `cs_n[0]` low, whatever the address and whatever valid flags windows 1 to 5 hold.
- R6: Once window 0 is valid, window 0 matches only through its base and mask, like the other windows.
- R7: During reset the port size of window 0 is loaded from `boot_ps_pins`. The other control fields of window 0 reset to 0, and all other window registers reset to 0.
- R8: Port size encoding: 2'b00 = 32-bit, 2'b01 = 8-bit, 2'b10 and 2'b11 = 16-bit. `cyc_lanes` (bit 3 = data bits 31:24) marks the active byte lanes, packed from the top: 4'b1111 for 32-bit, 4'b1100 for 16-bit, 4'b1000 for 8-bit.
- R9: A window matches when, for every address bit 23..16 whose mask bit is 0, the request address bit equals the base bit. Mask bits set to 1 are don't-care, and address bits 15..0 are never compared.
- R10: Apart from window 0 in boot mode, a window whose valid flag is clear never matches.
- R11: A write with `reg_wr_en` high updates the window selected by `reg_wr_win`. The field is chosen by `reg_wr_sel`: 2'b00 base = data[7:0]; 2'b01 mask = data[7:0] and valid = data[8]; 2'b10 control, where port size = data[1:0], burst enable = data[2] and auto-acknowledge = data[3]. Writes with `reg_wr_sel` = 2'b11 or `reg_wr_win` above 5 change nothing. A request in the same clock as a write decodes against the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_ps_pins | input | 2 | Strap levels giving the boot window port size, sampled in reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_win | input | 3 | Window index for the write |
| reg_wr_sel | input | 2 | Field select: base, mask/valid, control |
| reg_wr_data | input | 16 | Write data |
| req_valid | input | 1 | Bus request present this clock |
| req_addr | input | 24 | Request address |
| req_write | input | 1 | Request direction, 1 = write |
| cs_n | output | 6 | Active-low chip-selects |
| cyc_outcome | output | 2 | IDLE, NONE, SINGLE or MULTI |
| cyc_port_size | output | 2 | Port size of the cycle |
| cyc_burst_en | output | 1 | Burst permitted |
| cyc_ext_term | output | 1 | Cycle waits for external acknowledge |
| cyc_lanes | output | 4 | Active byte lanes, MSB-justified |
| cyc_addr | output | 24 | Registered request address |
| cyc_write | output | 1 | Registered request direction |

## Verification
Every result is due exactly one rising edge after the falling edge at which the bench drove the request. A register write affects only requests driven at later falling edges. The driver tags each expected item with the clock count at which the result must be present. The monitor samples on falling edges and pops only items whose due count equals the current count. Idle clocks and write-only clocks also push an idle expectation, so a result that appears a cycle early or late shows up as a mismatch. The reset state is checked while reset is held, and the strap pins are checked through a second reset with a different level.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

    localparam int LANE_W = 4;

    typedef enum logic [1:0] {
        OUT_IDLE   = 2'b00,
        OUT_NONE   = 2'b01,
        OUT_SINGLE = 2'b10,
        OUT_MULTI  = 2'b11
    } outcome_e;

    typedef enum logic [1:0] {
        SEL_BASE = 2'b00,
        SEL_MASK = 2'b01,
        SEL_CTRL = 2'b10,
        SEL_RSVD = 2'b11
    } reg_sel_e;

    localparam logic [1:0] PS_32 = 2'b00;
    localparam logic [1:0] PS_8  = 2'b01;

    typedef struct packed {
        logic [1:0] ps;
        logic       burst_en;
        logic       auto_ack;
    } win_ctrl_t;

    typedef struct packed {
        outcome_e          outcome;
        logic [1:0]        ps;
        logic              burst_en;
        logic              ext_term;
        logic [LANE_W-1:0] lanes;
    } cyc_attr_t;

    function automatic logic [LANE_W-1:0] lanes_for(input logic [1:0] ps);
        logic [LANE_W-1:0] m;
        if (ps == PS_32)     m = 4'b1111;
        else if (ps == PS_8) m = 4'b1000;
        else                 m = 4'b1100;
        return m;
    endfunction

endpackage

// File: rtl/cs_win_regs.sv
module cs_win_regs
    import cs_dec_pkg::*;
#(
    parameter int NUM_WIN = 6,
    parameter int CMP_W   = 8,
    parameter int REG_DW  = 16,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [1:0]                      boot_ps_pins,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_win,
    input  logic [1:0]                      wr_sel,
    input  logic [REG_DW-1:0]               wr_data,
    output logic [NUM_WIN-1:0][CMP_W-1:0]   base,
    output logic [NUM_WIN-1:0][CMP_W-1:0]   mask,
    output logic [NUM_WIN-1:0]              valid,
    output win_ctrl_t [NUM_WIN-1:0]         ctrl
);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic sel_me;
        assign sel_me = wr_en && (wr_win == IDX_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                base[w]  <= '0;
                mask[w]  <= '0;
                valid[w] <= 1'b0;
                if (w == 0) ctrl[w] <= '{ps: boot_ps_pins, burst_en: 1'b0, auto_ack: 1'b0};
                else        ctrl[w] <= '0;
            end else if (sel_me) begin
                case (reg_sel_e'(wr_sel))
                    SEL_BASE: base[w] <= wr_data[CMP_W-1:0];
                    SEL_MASK: begin
                        mask[w]  <= wr_data[CMP_W-1:0];
                        valid[w] <= wr_data[CMP_W];
                    end
                    SEL_CTRL: ctrl[w] <= '{ps: wr_data[1:0], burst_en: wr_data[2],
                                           auto_ack: wr_data[3]};
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/cs_win_match.sv
module cs_win_match #(
    parameter int NUM_WIN = 6,
    parameter int CMP_W   = 8
) (
    input  logic [CMP_W-1:0]                addr_hi,
    input  logic [NUM_WIN-1:0][CMP_W-1:0]   base,
    input  logic [NUM_WIN-1:0][CMP_W-1:0]   mask,
    input  logic [NUM_WIN-1:0]              valid,
    input  logic                            boot_mode,
    output logic [NUM_WIN-1:0]              hit
);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        logic raw_hit;
        assign raw_hit = valid[w] && (((addr_hi ^ base[w]) & ~mask[w]) == '0);
        if (w == 0) begin : g_boot
            assign hit[w] = boot_mode | raw_hit;
        end else begin : g_norm
            assign hit[w] = raw_hit & ~boot_mode;
        end
    end

endmodule

// File: rtl/cs_outcome_resolve.sv
module cs_outcome_resolve
    import cs_dec_pkg::*;
#(
    parameter int NUM_WIN = 6
) (
    input  logic                    req_valid,
    input  logic [NUM_WIN-1:0]      hit,
    input  win_ctrl_t [NUM_WIN-1:0] ctrl,
    output logic [NUM_WIN-1:0]      cs_n_d,
    output cyc_attr_t               attr_d
);

    win_ctrl_t sel_ctrl;
    int unsigned n_hit;

    always_comb begin
        sel_ctrl = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (hit[w]) sel_ctrl = win_ctrl_t'(sel_ctrl | ctrl[w]);
        end
    end

    assign n_hit = $countones(hit);

    always_comb begin
        cs_n_d = '1;
        attr_d = '{outcome: OUT_IDLE, ps: 2'b00, burst_en: 1'b0, ext_term: 1'b0, lanes: '0};
        if (req_valid) begin
            if (n_hit == 0) begin
                attr_d.outcome = OUT_NONE;
            end else if (n_hit == 1) begin
                cs_n_d          = ~hit;
                attr_d.outcome  = OUT_SINGLE;
                attr_d.ps       = sel_ctrl.ps;
                attr_d.burst_en = sel_ctrl.burst_en;
                attr_d.ext_term = ~sel_ctrl.auto_ack;
                attr_d.lanes    = lanes_for(sel_ctrl.ps);
            end else begin
                cs_n_d          = ~hit;
                attr_d.outcome  = OUT_MULTI;
                attr_d.ps       = PS_32;
                attr_d.burst_en = 1'b0;
                attr_d.ext_term = 1'b1;
                attr_d.lanes    = lanes_for(PS_32);
            end
        end
    end

endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
    import cs_dec_pkg::*;
#(
    parameter int NUM_WIN = 6,
    parameter int ADDR_W  = 24,
    parameter int CMP_LSB = 16,
    parameter int REG_DW  = 16,
    localparam int CMP_W  = ADDR_W - CMP_LSB,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         boot_ps_pins,
    input  logic               reg_wr_en,
    input  logic [IDX_W-1:0]   reg_wr_win,
    input  logic [1:0]         reg_wr_sel,
    input  logic [REG_DW-1:0]  reg_wr_data,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_write,
    output logic [NUM_WIN-1:0] cs_n,
    output logic [1:0]         cyc_outcome,
    output logic [1:0]         cyc_port_size,
    output logic               cyc_burst_en,
    output logic               cyc_ext_term,
    output logic [LANE_W-1:0]  cyc_lanes,
    output logic [ADDR_W-1:0]  cyc_addr,
    output logic               cyc_write
);

    logic [NUM_WIN-1:0][CMP_W-1:0] win_base;
    logic [NUM_WIN-1:0][CMP_W-1:0] win_mask;
    logic [NUM_WIN-1:0]            win_valid;
    win_ctrl_t [NUM_WIN-1:0]       win_ctrl;
    logic [NUM_WIN-1:0]            win_hit;
    logic                          boot_mode;
    logic [NUM_WIN-1:0]            cs_n_d;
    cyc_attr_t                     attr_d;
    cyc_attr_t                     attr_q;

    assign boot_mode = ~win_valid[0];

    cs_win_regs #(.NUM_WIN(NUM_WIN), .CMP_W(CMP_W), .REG_DW(REG_DW)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .boot_ps_pins (boot_ps_pins),
        .wr_en        (reg_wr_en),
        .wr_win       (reg_wr_win),
        .wr_sel       (reg_wr_sel),
        .wr_data      (reg_wr_data),
        .base         (win_base),
        .mask         (win_mask),
        .valid        (win_valid),
        .ctrl         (win_ctrl)
    );

    cs_win_match #(.NUM_WIN(NUM_WIN), .CMP_W(CMP_W)) u_match (
        .addr_hi   (req_addr[ADDR_W-1:CMP_LSB]),
        .base      (win_base),
        .mask      (win_mask),
        .valid     (win_valid),
        .boot_mode (boot_mode),
        .hit       (win_hit)
    );

    cs_outcome_resolve #(.NUM_WIN(NUM_WIN)) u_resolve (
        .req_valid (req_valid),
        .hit       (win_hit),
        .ctrl      (win_ctrl),
        .cs_n_d    (cs_n_d),
        .attr_d    (attr_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n      <= '1;
            attr_q    <= '{outcome: OUT_IDLE, ps: 2'b00, burst_en: 1'b0, ext_term: 1'b0, lanes: '0};
            cyc_addr  <= '0;
            cyc_write <= 1'b0;
        end else begin
            cs_n      <= cs_n_d;
            attr_q    <= attr_d;
            cyc_addr  <= req_valid ? req_addr : '0;
            cyc_write <= req_valid & req_write;
        end
    end

    assign cyc_outcome   = attr_q.outcome;
    assign cyc_port_size = attr_q.ps;
    assign cyc_burst_en  = attr_q.burst_en;
    assign cyc_ext_term  = attr_q.ext_term;
    assign cyc_lanes     = attr_q.lanes;

endmodule

// File: rtl/cs_window_decoder_chk.sv
module cs_window_decoder_chk #(
    parameter int NUM_WIN = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               boot_mode,
    input logic [NUM_WIN-1:0] cs_n,
    input logic [1:0]         cyc_outcome,
    input logic [1:0]         cyc_port_size,
    input logic               cyc_burst_en,
    input logic               cyc_ext_term,
    input logic [3:0]         cyc_lanes
);

    logic started;
    always_ff @(posedge clk) begin
        if (rst) started <= 1'b0;
        else     started <= 1'b1;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (started && !$past(req_valid)) |-> (cyc_outcome == 2'b00 && &cs_n));

    p_nomatch_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (cyc_outcome == 2'b01) |-> (&cs_n && !cyc_ext_term && cyc_lanes == 4'b0000));

    p_single_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        (cyc_outcome == 2'b10) |-> ($countones(~cs_n) == 1));

    p_multi_forced_r4: assert property (@(posedge clk) disable iff (rst)
        (cyc_outcome == 2'b11) |-> ($countones(~cs_n) >= 2 && !cyc_burst_en &&
                                    cyc_ext_term && cyc_port_size == 2'b00 &&
                                    cyc_lanes == 4'b1111));

    p_boot_claims_r5: assert property (@(posedge clk) disable iff (rst)
        (started && $past(boot_mode) && $past(req_valid)) |->
        (!cs_n[0] && &cs_n[NUM_WIN-1:1] && cyc_outcome == 2'b10));

    p_lanes_match_r8: assert property (@(posedge clk) disable iff (rst)
        (cyc_outcome == 2'b10) |->
        (cyc_lanes == ((cyc_port_size == 2'b00) ? 4'b1111 :
                       (cyc_port_size == 2'b01) ? 4'b1000 : 4'b1100)));

endmodule

bind cs_window_decoder cs_window_decoder_chk #(.NUM_WIN(NUM_WIN)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .boot_mode     (boot_mode),
    .cs_n          (cs_n),
    .cyc_outcome   (cyc_outcome),
    .cyc_port_size (cyc_port_size),
    .cyc_burst_en  (cyc_burst_en),
    .cyc_ext_term  (cyc_ext_term),
    .cyc_lanes     (cyc_lanes)
);

// File: tb/cs_window_decoder_bench.sv
`timescale 1ns/1ps
module cs_window_decoder_bench;

    localparam int NW = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  boot_ps_pins = 2'b01;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_win = '0;
    logic [1:0]  reg_wr_sel = '0;
    logic [15:0] reg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [5:0]  cs_n;
    logic [1:0]  cyc_outcome, cyc_port_size;
    logic        cyc_burst_en, cyc_ext_term, cyc_write;
    logic [3:0]  cyc_lanes;
    logic [23:0] cyc_addr;

    always #2.5 clk = ~clk;

    cs_window_decoder u_cs_window_decoder (
        .clk(clk), .rst(rst), .boot_ps_pins(boot_ps_pins),
        .reg_wr_en(reg_wr_en), .reg_wr_win(reg_wr_win), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .cs_n(cs_n), .cyc_outcome(cyc_outcome),
        .cyc_port_size(cyc_port_size), .cyc_burst_en(cyc_burst_en),
        .cyc_ext_term(cyc_ext_term), .cyc_lanes(cyc_lanes), .cyc_addr(cyc_addr),
        .cyc_write(cyc_write)
    );

    // result vector: cs_n(6) outcome(2) ps(2) burst ext lanes(4) addr(24) write
    typedef logic [40:0] res_t;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    res_t expq[$];
    int   dueq[$];
    string tagq[$];

    // shadow of the programmed windows
    logic [7:0] sh_base [NW];
    logic [7:0] sh_mask [NW];
    logic       sh_val  [NW];
    logic [1:0] sh_ps   [NW];
    logic       sh_bur  [NW];
    logic       sh_ack  [NW];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [3:0] exp_lanes(input logic [1:0] ps);
        if (ps == 2'b00) return 4'b1111;
        if (ps == 2'b01) return 4'b1000;
        return 4'b1100;
    endfunction

    function automatic res_t predict(input logic rv, input logic [23:0] a, input logic wr);
        logic [5:0] hits;
        int         n;
        int         k;
        hits = '0;
        n = 0;
        k = 0;
        if (!rv) return '1 << 35;
        for (int w = 0; w < NW; w++) begin
            logic m;
            m = sh_val[w] && (((a[23:16] ^ sh_base[w]) & ~sh_mask[w]) == 8'h00);
            if (!sh_val[0]) m = (w == 0);
            if (m) begin hits[w] = 1'b1; n++; k = w; end
        end
        if (n == 0) return {6'h3F, 2'b01, 2'b00, 1'b0, 1'b0, 4'h0, a, wr};
        if (n == 1) return {~hits, 2'b10, sh_ps[k], sh_bur[k], ~sh_ack[k],
                            exp_lanes(sh_ps[k]), a, wr};
        return {~hits, 2'b11, 2'b00, 1'b0, 1'b1, 4'hF, a, wr};
    endfunction

    task automatic shadow_reset();
        for (int w = 0; w < NW; w++) begin
            sh_base[w] = '0; sh_mask[w] = '0; sh_val[w] = 1'b0;
            sh_ps[w] = '0; sh_bur[w] = 1'b0; sh_ack[w] = 1'b0;
        end
        sh_ps[0] = boot_ps_pins;
    endtask

    // one clock: optional write, optional request; called at a falling edge
    task automatic step(input logic we, input logic [2:0] win, input logic [1:0] sel,
                        input logic [15:0] d, input logic rv, input logic [23:0] a,
                        input logic wr, input string tag);
        reg_wr_en = we; reg_wr_win = win; reg_wr_sel = sel; reg_wr_data = d;
        req_valid = rv; req_addr = a; req_write = wr;
        expq.push_back(predict(rv, a, wr));
        dueq.push_back(cyc + 1);
        tagq.push_back(tag);
        if (we && win < 3'd6) begin
            case (sel)
                2'b00: sh_base[win] = d[7:0];
                2'b01: begin sh_mask[win] = d[7:0]; sh_val[win] = d[8]; end
                2'b10: begin sh_ps[win] = d[1:0]; sh_bur[win] = d[2]; sh_ack[win] = d[3]; end
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic wreg(input logic [2:0] win, input logic [1:0] sel, input logic [15:0] d,
                        input string tag);
        step(1'b1, win, sel, d, 1'b0, 24'h0, 1'b0, tag);
    endtask

    task automatic req(input logic [23:0] a, input logic wr, input string tag);
        step(1'b0, 3'd0, 2'b00, 16'h0, 1'b1, a, wr, tag);
    endtask

    task automatic do_reset(input logic [1:0] pins);
        rst = 1'b1;
        boot_ps_pins = pins;
        req_valid = 1'b0;
        reg_wr_en = 1'b0;
        repeat (3) @(negedge clk);
        n_chk++;
        if ({cs_n, cyc_outcome, cyc_lanes, cyc_addr} !== {6'h3F, 2'b00, 4'h0, 24'h0}) begin
            n_fail++;
            $display("FAIL R1 reset state actual=%h expected=%h",
                     {cs_n, cyc_outcome, cyc_lanes, cyc_addr}, {6'h3F, 2'b00, 4'h0, 24'h0});
        end
        shadow_reset();
        rst = 1'b0;
    endtask

    // monitor: compare each item in the cycle it is due
    always @(negedge clk) begin
        while (dueq.size() > 0 && dueq[0] == cyc) begin
            res_t  got;
            res_t  exp;
            string tag;
            got = {cs_n, cyc_outcome, cyc_port_size, cyc_burst_en, cyc_ext_term,
                   cyc_lanes, cyc_addr, cyc_write};
            exp = expq.pop_front();
            tag = tagq.pop_front();
            void'(dueq.pop_front());
            n_chk++;
            if (got !== exp) begin
                n_fail++;
                $display("FAIL %s actual=%h expected=%h", tag, got, exp);
            end
        end
    end

    initial begin
        fork
            begin
                #500000;
                n_chk++;
                n_fail++;
                $display("FAIL R1 watchdog actual=hung expected=finished");
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        join_none

        @(negedge clk);
        do_reset(2'b01);
        step(1'b0, 3'd0, 2'b00, 16'h0, 1'b0, 24'h0, 1'b0, "R1 idle after reset");

        // boot mode: window 1 programmed valid but must stay off
        wreg(3'd1, 2'b00, 16'h0010, "R11 write base w1");
        wreg(3'd1, 2'b01, 16'h0100, "R11 write mask/valid w1");
        wreg(3'd1, 2'b10, 16'h0004, "R11 write ctrl w1");
        req(24'h10_2000, 1'b0, "R5 boot claims w1 address");
        req(24'hFF_FFFF, 1'b1, "R5 R7 boot top address, 8-bit strap");
        req(24'h00_0000, 1'b0, "R5 R8 boot bottom address");
        step(1'b0, 3'd0, 2'b00, 16'h0, 1'b0, 24'h0, 1'b0, "R1 idle between requests");

        // leave boot mode: window 0 at 0x00xxxx..0x0Fxxxx, 16-bit, auto-ack
        wreg(3'd0, 2'b10, 16'h000A, "R11 write ctrl w0");
        wreg(3'd0, 2'b01, 16'h010F, "R11 write mask/valid w0");
        req(24'h05_1234, 1'b0, "R6 R9 w0 via mask");
        req(24'h0F_FFFF, 1'b1, "R9 w0 upper edge");
        req(24'h10_0000, 1'b0, "R3 single w1");
        req(24'h80_0000, 1'b0, "R2 no window");
        req(24'h20_0000, 1'b1, "R6 w0 no longer claims all");

        // overlapping window 2 covers 0x10..0x11, 8-bit with burst
        wreg(3'd2, 2'b00, 16'h0010, "R11 write base w2");
        wreg(3'd2, 2'b10, 16'h000D, "R11 write ctrl w2");
        req(24'h11_0000, 1'b0, "R10 w2 not valid yet");
        wreg(3'd2, 2'b01, 16'h0101, "R11 write mask/valid w2");
        req(24'h11_4000, 1'b0, "R3 R8 single w2 8-bit");
        req(24'h10_ABCD, 1'b1, "R4 overlap w1 w2");

        // ignored writes: reserved field and out-of-range window
        wreg(3'd2, 2'b11, 16'hFFFF, "R11 reserved select ignored");
        wreg(3'd7, 2'b01, 16'h01FF, "R11 window 7 ignored");
        req(24'h11_0000, 1'b0, "R11 w2 unchanged after ignored writes");
        req(24'h40_0000, 1'b0, "R11 no stray window after ignored writes");

        // write and request in the same clock: old contents used
        step(1'b1, 3'd2, 2'b01, 16'h0001, 1'b1, 24'h11_0000, 1'b0,
             "R11 same-clock write uses old value");
        req(24'h11_0000, 1'b0, "R10 w2 cleared valid never matches");
        req(24'h10_0000, 1'b0, "R3 w1 single again");

        // second reset with a 16-bit strap
        do_reset(2'b10);
        req(24'h10_0000, 1'b0, "R7 R5 boot with 16-bit strap");
        req(24'h33_0000, 1'b1, "R7 boot 16-bit lanes");
        step(1'b0, 3'd0, 2'b00, 16'h0, 1'b0, 24'h0, 1'b0, "R1 idle at end");

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule